// File: doc/BRIEF.md
# Reed-Solomon Syndrome Error Detector

This block sits on the read path of a page store. It watches a stream of bytes that makes up one stored packet: 512 data bytes, then 10 bytes that hold eight packed 10-bit check symbols. The block turns the stream into a 520-symbol codeword over GF(2^10) and evaluates it, one symbol per accepted byte, at the eight code roots alpha^0 through alpha^7. The code can repair up to four symbol errors, which is why it needs eight syndromes.

When the last check byte has been taken, the eight syndromes are frozen and a one-cycle strobe announces them. An error flag reports whether any syndrome is nonzero. A clean packet gives all-zero syndromes and can be used as read. Otherwise a separate correction engine uses the syndromes to decide whether the packet can be repaired or must be discarded. Bytes may arrive with idle cycles between them, and a new packet may start in the cycle right after the previous one ends.

Top module: `rsd_syndrome_top`

## Requirements
- R1: While reset is high and in the cycle after it, syn_valid is 0, every syndrome is 0 and error_present is 0.
- R2: A byte is taken only in a cycle where byte_valid is 1. Idle cycles change neither the position within the packet nor the syndromes, and produce no syn_valid.
- R3: Bytes 0 to 511 of a packet are data symbols, zero-extended to 10 bits (the upper two bits are 0). Byte 0 is the coefficient of x^519 and byte 511 is the coefficient of x^8.
- R4: Bytes 512 to 521 form an 80-bit check vector in little-endian bit order: vector bit k is bit k mod 8 of byte 512+k/8. Check symbol j is vector bits 10j to 10j+9. Check symbol 0 is the coefficient of x^7 and check symbol 7 is the coefficient of x^0.
- R5: Syndrome i equals the received polynomial evaluated at alpha^i, for i = 0 to 7. The field is GF(2^10) with modulus x^10+x^3+1 and alpha = 2. Syndrome i appears on syndromes bits [10i+9:10i].
- R6: syn_valid is 1 for exactly one cycle: the cycle after the byte with index 521 is taken. It is 0 at all other times.
- R7: From that strobe until the next packet's first byte is taken, syndromes and error_present stay unchanged.
- R8: error_present is 1 exactly when some syndrome is nonzero. A correctly encoded packet gives all-zero syndromes. A packet with 1 to 4 corrupted symbols gives error_present = 1.
- R9: The byte taken after index 521 is byte 0 of a new packet, even if it arrives in the same cycle as the syn_valid strobe.
- R10: A reset in the middle of a packet discards it. The next byte taken is byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | A stream byte is present on byte_data |
| byte_data | input | 8 | Stream byte |
| syn_valid | output | 1 | One-cycle strobe: the syndromes of a full packet are ready |
| syndromes | output | 80 | Eight 10-bit syndromes; syndrome i at bits [10i+9:10i] |
| error_present | output | 1 | Some syndrome is nonzero |

## Verification
A wrong byte count or a wrong unpacking state shows up within one packet. It either moves the syn_valid strobe away from the cycle after byte 521, or it leaves nonzero syndromes on a clean packet. Either fault is seen on the same cycle the strobe is due. A wrong field constant or a wrong Horner update gives syndromes that differ from the bench's direct evaluation at the first strobe. Hold faults and reset faults are caught on every cycle, because the bench compares the held syndromes against its model at every clock.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    localparam int SYM_W      = 10;
    localparam int BYTE_W     = 8;
    localparam int DATA_SYMS  = 512;
    localparam int PAR_SYMS   = 8;
    localparam int PAR_BYTES  = (PAR_SYMS * SYM_W) / BYTE_W;
    localparam int PKT_BYTES  = DATA_SYMS + PAR_BYTES;
    localparam int CNT_W      = $clog2(PKT_BYTES);
    localparam int BUF_W      = 2 * BYTE_W;
    localparam int FILL_W     = $clog2(BUF_W + 1);
    localparam int SYN_FLAT_W = PAR_SYMS * SYM_W;

    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic {
        PH_DATA   = 1'b0,
        PH_PARITY = 1'b1
    } phase_e;

    typedef struct packed {
        logic valid;
        logic first;
        sym_t value;
    } sym_beat_t;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t            acc;
        logic [SYM_W:0]  wide;
        acc = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            wide = {acc, 1'b0};
            if (wide[SYM_W]) wide = wide ^ FIELD_POLY;
            acc = wide[SYM_W-1:0];
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(input int n);
        sym_t r;
        r = sym_t'(1);
        for (int k = 0; k < n; k++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

endpackage

// File: rtl/rsd_stream_unpack.sv
module rsd_stream_unpack
    import rsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output sym_beat_t         beat,
    output logic              pkt_done
);

    logic [CNT_W-1:0]  byte_cnt;
    logic [BUF_W-1:0]  bit_buf;
    logic [FILL_W-1:0] fill;

    phase_e            phase;
    logic [BUF_W-1:0]  merged;
    logic [FILL_W-1:0] fill_sum;
    logic              emit;

    always_comb begin
        phase    = (byte_cnt >= CNT_W'(DATA_SYMS)) ? PH_PARITY : PH_DATA;
        merged   = bit_buf | (BUF_W'(byte_data) << fill);
        fill_sum = fill + FILL_W'(BYTE_W);
        emit     = (fill_sum >= FILL_W'(SYM_W));
        pkt_done = byte_valid && (byte_cnt == CNT_W'(PKT_BYTES - 1));
    end

    always_comb begin
        beat = '0;
        if (phase == PH_DATA) begin
            beat.valid = byte_valid;
            beat.first = (byte_cnt == '0);
            beat.value = sym_t'(byte_data);
        end else begin
            beat.valid = byte_valid && emit;
            beat.first = 1'b0;
            beat.value = merged[SYM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt <= '0;
            bit_buf  <= '0;
            fill     <= '0;
        end else if (byte_valid) begin
            byte_cnt <= pkt_done ? '0 : byte_cnt + 1'b1;
            if (phase == PH_PARITY) begin
                if (emit) begin
                    bit_buf <= merged >> SYM_W;
                    fill    <= fill_sum - FILL_W'(SYM_W);
                end else begin
                    bit_buf <= merged;
                    fill    <= fill_sum;
                end
            end
        end
    end

endmodule

// File: rtl/rsd_horner_cell.sv
module rsd_horner_cell
    import rsd_pkg::*;
#(
    parameter int ROOT_IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  sym_beat_t beat,
    output sym_t      syn
);

    localparam sym_t ROOT = gf_alpha_pow(ROOT_IDX);

    sym_t scaled;

    always_comb begin
        scaled = beat.first ? '0 : gf_mul(syn, ROOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            syn <= '0;
        end else if (beat.valid) begin
            syn <= scaled ^ beat.value;
        end
    end

endmodule

// File: rtl/rsd_verdict.sv
module rsd_verdict
    import rsd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pkt_done,
    input  logic [SYN_FLAT_W-1:0] syn_flat,
    output logic                  syn_valid,
    output logic                  error_present
);

    logic [PAR_SYMS-1:0] nonzero;

    for (genvar g = 0; g < PAR_SYMS; g++) begin : g_nz
        assign nonzero[g] = |syn_flat[g*SYM_W +: SYM_W];
    end

    assign error_present = |nonzero;

    always_ff @(posedge clk) begin
        if (rst) syn_valid <= 1'b0;
        else     syn_valid <= pkt_done;
    end

endmodule

// File: rtl/rsd_syndrome_top.sv
module rsd_syndrome_top
    import rsd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  byte_valid,
    input  logic [BYTE_W-1:0]     byte_data,
    output logic                  syn_valid,
    output logic [SYN_FLAT_W-1:0] syndromes,
    output logic                  error_present
);

    sym_beat_t beat;
    logic      pkt_done;

    rsd_stream_unpack u_unpack (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .beat       (beat),
        .pkt_done   (pkt_done)
    );

    for (genvar i = 0; i < PAR_SYMS; i++) begin : g_cell
        rsd_horner_cell #(.ROOT_IDX(i)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .beat (beat),
            .syn  (syndromes[i*SYM_W +: SYM_W])
        );
    end

    rsd_verdict u_verdict (
        .clk           (clk),
        .rst           (rst),
        .pkt_done      (pkt_done),
        .syn_flat      (syndromes),
        .syn_valid     (syn_valid),
        .error_present (error_present)
    );

endmodule

// File: rtl/rsd_syndrome_chk.sv
module rsd_syndrome_chk
    import rsd_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  byte_valid,
    input logic [BYTE_W-1:0]     byte_data,
    input logic                  syn_valid,
    input logic [SYN_FLAT_W-1:0] syndromes,
    input logic                  error_present
);

    int   seen;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= 0;
            done_q <= 1'b0;
        end else begin
            done_q <= byte_valid && (seen == PKT_BYTES - 1);
            if (byte_valid) seen <= (seen == PKT_BYTES - 1) ? 0 : seen + 1;
        end
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!syn_valid && syndromes == '0 && !error_present));

    // R2
    a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> !syn_valid);

    // R6
    a_r6_strobe_cadence: assert property (@(posedge clk) disable iff (rst)
        syn_valid == done_q);

    // R6
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
        syn_valid |=> !syn_valid);

    // R7
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> ($stable(syndromes) && $stable(error_present)));

    // R8
    a_r8_clean_no_flag: assert property (@(posedge clk) disable iff (rst)
        (syndromes == '0) |-> !error_present);

endmodule

bind rsd_syndrome_top rsd_syndrome_chk u_chk (.*);

// File: tb/sim_rsd_syndrome_top.sv
module sim_rsd_syndrome_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        syn_valid;
    logic [79:0] syndromes;
    logic        error_present;

    always #4 clk = ~clk;

    rsd_syndrome_top u0 (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .syn_valid(syn_valid), .syndromes(syndromes), .error_present(error_present)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int gexp [0:1023];
    int glog [0:1023];
    int gcoef [0:8];
    int sym  [0:519];
    int pkt  [0:521];

    logic [79:0] cur_exp;
    logic        cur_ep;

    // bench model
    int          mcnt;
    logic        exp_sv;
    logic [79:0] exp_hold;
    logic        exp_ep;
    logic        hold_ok;

    function automatic int bmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return gexp[(glog[a] + glog[b]) % 1023];
    endfunction

    task automatic check(string req, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mcnt <= 0; exp_sv <= 0; exp_hold <= '0; exp_ep <= 0; hold_ok <= 1;
        end else if (byte_valid) begin
            if (mcnt == 521) begin
                mcnt <= 0; exp_sv <= 1; exp_hold <= cur_exp; exp_ep <= cur_ep; hold_ok <= 1;
            end else begin
                mcnt <= mcnt + 1; exp_sv <= 0; hold_ok <= 0;
            end
        end else begin
            exp_sv <= 0;
        end
    end

    always @(negedge clk) begin
        if (!finished && rst !== 1'bx) begin
            check("R6 syn_valid timing", 80'(syn_valid), 80'(exp_sv));
            if (hold_ok) begin
                check("R5/R7/R1 syndromes", syndromes, exp_hold);
                check("R8/R7/R1 error_present", 80'(error_present), 80'(exp_ep));
            end
        end
    end

    task automatic build_field();
        int x = 1;
        for (int i = 0; i < 1023; i++) begin
            gexp[i] = x;
            glog[x] = i;
            x = x << 1;
            if (x & 1024) x = x ^ 'h409;
        end
        for (int d = 0; d <= 8; d++) gcoef[d] = 0;
        gcoef[0] = 1;
        for (int i = 0; i < 8; i++) begin
            for (int d = 8; d >= 0; d--)
                gcoef[d] = bmul(gcoef[d], gexp[i]) ^ ((d > 0) ? gcoef[d-1] : 0);
        end
    endtask

    // pattern 0 random, 1 all 0xFF, 2 all zero
    task automatic make_packet(int nerr, int pattern);
        int par [0:7];
        int fb;
        bit used [0:519];
        logic [79:0] pb;
        for (int j = 0; j < 512; j++)
            sym[j] = (pattern == 1) ? 255 : (pattern == 2) ? 0 : int'($urandom_range(0, 255));
        for (int k = 0; k < 8; k++) par[k] = 0;
        for (int j = 0; j < 512; j++) begin
            fb = sym[j] ^ par[0];
            for (int k = 0; k < 7; k++) par[k] = par[k+1] ^ bmul(fb, gcoef[7-k]);
            par[7] = bmul(fb, gcoef[0]);
        end
        for (int k = 0; k < 8; k++) sym[512+k] = par[k];
        for (int j = 0; j < 520; j++) used[j] = 0;
        for (int e = 0; e < nerr; e++) begin
            int pos;
            do pos = int'($urandom_range(0, 519)); while (used[pos]);
            used[pos] = 1;
            sym[pos] = sym[pos] ^ ((pos < 512) ? int'($urandom_range(1, 255))
                                              : int'($urandom_range(1, 1023)));
        end
        for (int j = 0; j < 512; j++) pkt[j] = sym[j];
        for (int k = 0; k < 8; k++) pb[10*k +: 10] = 10'(sym[512+k]);
        for (int b = 0; b < 10; b++) pkt[512+b] = int'(pb[8*b +: 8]);
        cur_exp = '0;
        for (int i = 0; i < 8; i++) begin
            int s = 0;
            for (int j = 0; j < 520; j++)
                s = s ^ bmul(sym[j], gexp[(i * (519 - j)) % 1023]);
            cur_exp[10*i +: 10] = 10'(s);
        end
        cur_ep = (cur_exp != '0);
        checks++;
        if (cur_ep != (nerr != 0)) begin
            errors++;
            $display("FAIL R8 nerr=%0d actual=%0d expected=%0d", nerr, cur_ep, nerr != 0);
        end
    endtask

    task automatic send_bytes(int first, int last, int gap_pct);
        for (int b = first; b <= last; b++) begin
            while (gap_pct > 0 && int'($urandom_range(0, 99)) < gap_pct) begin
                byte_valid = 0;
                byte_data  = 8'($urandom);
                @(posedge clk); #1;
            end
            byte_valid = 1;
            byte_data  = 8'(pkt[b]);
            @(posedge clk); #1;
        end
        byte_valid = 0;
    endtask

    task automatic run_packet(int nerr, int pattern, int gap_pct, bit tail_idle);
        make_packet(nerr, pattern);
        send_bytes(0, 521, gap_pct);
        if (tail_idle) repeat (3) begin @(posedge clk); #1; end
    endtask

    initial begin
        build_field();
        rst = 1; byte_valid = 0; byte_data = 0;
        cur_exp = '0; cur_ep = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 syn_valid in reset", 80'(syn_valid), 80'(0));
        check("R1 syndromes in reset", syndromes, 80'(0));
        rst = 0;
        repeat (2) begin @(posedge clk); #1; end
        // R3 R5 R8 clean packets of several patterns
        run_packet(0, 2, 0, 1);
        run_packet(0, 1, 0, 1);
        run_packet(0, 0, 0, 1);
        // R2 idle gaps inside the stream
        run_packet(0, 0, 30, 1);
        run_packet(2, 0, 30, 1);
        // R4 R8 error counts 1 to 4
        for (int n = 1; n <= 4; n++)
            for (int r = 0; r < 3; r++) run_packet(n, 0, 5, 1);
        // R9 back-to-back packets
        for (int r = 0; r < 4; r++) run_packet(r % 3, 0, 0, 0);
        repeat (2) begin @(posedge clk); #1; end
        // R10 reset mid packet
        make_packet(1, 0);
        send_bytes(0, 300, 0);
        rst = 1;
        @(posedge clk); #1;
        check("R10 syndromes cleared", syndromes, 80'(0));
        rst = 0;
        run_packet(0, 0, 0, 1);
        run_packet(3, 0, 10, 1);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule